// File: doc/BRIEF.md
# Paged Transmit Queue Fetcher

This block drains a transmit queue that software builds in host memory as a chain of fixed-size pages. Software writes frames one after another into the current page and rings a doorbell once for each frame it adds. The fetcher keeps a count of these doorbell strokes. While the count is non-zero, it reads the 32-bit header word at its current position. It then either hands the frame's descriptor downstream or, when the header marks a link record, follows the record to the next page.

Every link record the fetcher consumes pulses a strobe toward the interrupt logic, so that software can reclaim the page just left behind. Before the first fetch, the queue's start address is loaded as two 32-bit halves while a hold input is asserted. Releasing the hold starts the walk from that address. Asserting the hold again aborts the walk and discards all outstanding work. A malformed header stops the fetcher in an error state until the next hold.

Top module: `paged_tx_fetcher`

## Requirements
- R1: After reset and for as long as `hold_i` is high, the block makes no memory read, presents no frame, raises no link strobe and shows no error.
- R2: The base address halves are captured from `base_data_i` only while `hold_i` is high. Writes made while `hold_i` is low have no effect. After the hold is released, the first header read is at the captured base address.
- R3: Each `bell_i` cycle adds one pending frame. The block reads headers only while at least one frame is pending, and each accepted frame removes one. N doorbells therefore yield exactly N frames.
- R4: A header word carries the record size in bits 15:0 and the record type in bits 31:16. A frame is presented on `frm_*` with the address of its header, its size and its type. It is held unchanged until `frm_ready_i` is high.
- R5: After a frame is accepted, the next header is read at the frame's address plus its size rounded up to a multiple of 4.
- R6: A header of type 0x1001 with size 12 is a link record. The block reads the low address half at header+4 and the high half at header+8. It then reads the next header at that address, at page offset 0. A link record does not use up a pending frame.
- R7: Each consumed link record raises `link_evt_o` for exactly one cycle.
- R8: A header whose size is 0, whose rounded size would run past the end of the page (`PAGE_BYTES`, 2048), or which has the link type with a size other than 12 stops the block. `err_o` is then raised and held, and no further reads or frames occur until the hold.
- R9: Raising `hold_i` aborts any fetch or frame presentation in progress and clears both the pending count and the error. Doorbells during the hold are ignored.
- R10: A record that ends exactly on the page end is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Queue reset/hold level; low lets the fetcher run |
| base_lo_wr_i | input | 1 | Write strobe for the low base address half |
| base_hi_wr_i | input | 1 | Write strobe for the high base address half |
| base_data_i | input | 32 | Base address half being written |
| bell_i | input | 1 | Doorbell: one more frame is ready in memory |
| rd_req_o | output | 1 | Memory read request, held until answered |
| rd_addr_o | output | 64 | Byte address of the 32-bit word requested |
| rd_rsp_i | input | 1 | Memory response strobe |
| rd_data_i | input | 32 | Read data, valid with `rd_rsp_i` |
| frm_valid_o | output | 1 | A frame descriptor is presented |
| frm_ready_i | input | 1 | Downstream takes the frame |
| frm_addr_o | output | 64 | Address of the frame's header |
| frm_size_o | output | 16 | Frame size in bytes |
| frm_type_o | output | 16 | Frame type |
| link_evt_o | output | 1 | One-cycle pulse per consumed link record |
| err_o | output | 1 | Malformed header; fetcher stopped |

## Verification
The assertions assume that memory answers each request with exactly one `rd_rsp_i`, and only while `rd_req_o` is still high. They also assume that base halves are written only under hold. The bench's memory model answers one cycle after it sees a request and then stays quiet for a cycle before it can answer again, so a response never lands on a request that has already been withdrawn. Every base load happens inside a hold window that lasts a few cycles past the last write. Frame readiness is either held high throughout a test or deliberately held low to probe the stall behaviour.

// File: rtl/paged_tx_fetcher.sv
module paged_tx_fetcher #(
  parameter int          PAGE_BYTES = 2048,
  parameter int          CNT_W      = 8,
  parameter int          LINK_BYTES = 12,
  parameter logic [15:0] LINK_TYPE  = 16'h1001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hold_i,
  input  logic        base_lo_wr_i,
  input  logic        base_hi_wr_i,
  input  logic [31:0] base_data_i,
  input  logic        bell_i,
  output logic        rd_req_o,
  output logic [63:0] rd_addr_o,
  input  logic        rd_rsp_i,
  input  logic [31:0] rd_data_i,
  output logic        frm_valid_o,
  input  logic        frm_ready_i,
  output logic [63:0] frm_addr_o,
  output logic [15:0] frm_size_o,
  output logic [15:0] frm_type_o,
  output logic        link_evt_o,
  output logic        err_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_LLO, S_LHI, S_OUT, S_ERR} st_t;

  st_t              st;
  logic [31:0]      base_lo, base_hi, link_lo;
  logic [63:0]      page;
  logic [OFF_W-1:0] off;
  logic [CNT_W-1:0] pend;
  logic [15:0]      hdr_size, hdr_type;
  logic [16:0]      hdr_pad;
  logic             link_q;

  logic [63:0] cur_addr;
  logic [16:0] sz_pad;
  logic [17:0] end_pos;
  logic        is_link, hdr_bad, take, inc;

  assign cur_addr = page + 64'(off);
  assign sz_pad   = ({1'b0, rd_data_i[15:0]} + 17'd3) & ~17'd3;
  assign end_pos  = 18'(off) + 18'(sz_pad);
  assign is_link  = rd_data_i[31:16] == LINK_TYPE;
  assign hdr_bad  = (rd_data_i[15:0] == 16'd0) || (end_pos > 18'(PAGE_BYTES)) ||
                    (is_link && rd_data_i[15:0] != 16'(LINK_BYTES));

  assign rd_req_o    = (st == S_HDR) || (st == S_LLO) || (st == S_LHI);
  assign rd_addr_o   = cur_addr + ((st == S_LLO) ? 64'd4 : (st == S_LHI) ? 64'd8 : 64'd0);
  assign frm_valid_o = st == S_OUT;
  assign frm_addr_o  = cur_addr;
  assign frm_size_o  = hdr_size;
  assign frm_type_o  = hdr_type;
  assign link_evt_o  = link_q;
  assign err_o       = st == S_ERR;

  assign take = (st == S_OUT) && frm_ready_i;
  assign inc  = bell_i && (pend != CNT_MAX || take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      base_lo  <= '0;
      base_hi  <= '0;
      link_lo  <= '0;
      page     <= '0;
      off      <= '0;
      pend     <= '0;
      hdr_size <= '0;
      hdr_type <= '0;
      hdr_pad  <= '0;
      link_q   <= 1'b0;
    end else if (hold_i) begin
      st     <= S_IDLE;
      pend   <= '0;
      off    <= '0;
      link_q <= 1'b0;
      page   <= {base_hi, base_lo};
      if (base_lo_wr_i) base_lo <= base_data_i;
      if (base_hi_wr_i) base_hi <= base_data_i;
    end else begin
      link_q <= 1'b0;
      pend   <= pend + CNT_W'(inc) - CNT_W'(take);
      case (st)
        S_IDLE: if (pend != '0) st <= S_HDR;
        S_HDR: if (rd_rsp_i) begin
          hdr_size <= rd_data_i[15:0];
          hdr_type <= rd_data_i[31:16];
          hdr_pad  <= sz_pad;
          if (hdr_bad)      st <= S_ERR;
          else if (is_link) st <= S_LLO;
          else              st <= S_OUT;
        end
        S_LLO: if (rd_rsp_i) begin
          link_lo <= rd_data_i;
          st      <= S_LHI;
        end
        S_LHI: if (rd_rsp_i) begin
          page   <= {rd_data_i, link_lo};
          off    <= '0;
          link_q <= 1'b1;
          st     <= S_IDLE;
        end
        S_OUT: if (frm_ready_i) begin
          off <= OFF_W'(18'(off) + 18'(hdr_pad));
          st  <= S_IDLE;
        end
        default: st <= S_ERR;
      endcase
    end
  end

  a_r1_quiet_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !rd_req_o && !frm_valid_o && !link_evt_o);

  a_r3_frame_has_credit: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid_o |-> pend != '0);

  a_r4_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid_o && !frm_ready_i && !hold_i |=>
      frm_valid_o && $stable(frm_addr_o) && $stable(frm_size_o) && $stable(frm_type_o));

  a_r7_link_single: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt_o |=> !link_evt_o);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !hold_i |=> err_o && !rd_req_o && !frm_valid_o);
endmodule

// File: tb/tb_paged_tx_fetcher.sv
module tb_paged_tx_fetcher;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_i = 1'b1;
  logic base_lo_wr_i = 1'b0, base_hi_wr_i = 1'b0;
  logic [31:0] base_data_i = '0;
  logic bell_i = 1'b0;
  logic rd_req_o;
  logic [63:0] rd_addr_o;
  logic rd_rsp_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic frm_valid_o, frm_ready_i = 1'b1;
  logic [63:0] frm_addr_o;
  logic [15:0] frm_size_o, frm_type_o;
  logic link_evt_o, err_o;

  always #5 clk = ~clk;

  paged_tx_fetcher dut (.*);

  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    rd_rsp_i  <= rd_req_o && !rd_rsp_i;
    rd_data_i <= mem[rd_addr_o[11:2]];
  end

  int total = 0, bad = 0;
  int nfr = 0, nlink = 0;
  logic [63:0] g_addr [0:31];
  logic [15:0] g_size [0:31];
  logic [15:0] g_type [0:31];

  always @(negedge clk) begin
    if (frm_valid_o && frm_ready_i && !hold_i) begin
      if (nfr < 32) begin
        g_addr[nfr] = frm_addr_o; g_size[nfr] = frm_size_o; g_type[nfr] = frm_type_o;
      end
      nfr = nfr + 1;
    end
    if (link_evt_o) nlink = nlink + 1;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hdr(input int a, input int sz, input int ty);
    mem[a[11:2]] = {ty[15:0], sz[15:0]};
  endtask

  task automatic load_base(input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk) hold_i = 1'b1;
    base_lo_wr_i = 1'b1; base_data_i = lo;
    @(negedge clk) base_lo_wr_i = 1'b0; base_hi_wr_i = 1'b1; base_data_i = hi;
    @(negedge clk) base_hi_wr_i = 1'b0;
    repeat (3) @(negedge clk);
    nfr = 0; nlink = 0;
    hold_i = 1'b0;
  endtask

  task automatic ring(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bell_i = 1'b1;
      @(negedge clk) bell_i = 1'b0;
    end
  endtask

  task automatic wait_frames(input int n);
    for (int i = 0; i < 200 && nfr < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!rd_req_o, "R1 no read in hold", rd_req_o, 0);
    chk(!frm_valid_o, "R1 no frame in hold", frm_valid_o, 0);
    chk(!err_o && !link_evt_o, "R1 no err/link in hold", {err_o, link_evt_o}, 0);
  endtask

  task automatic t_basic;
    hdr(32'h00, 20, 16'h50); hdr(32'h14, 13, 16'h51); hdr(32'h24, 6, 16'h52); hdr(32'h2C, 8, 16'h53);
    load_base(32'h0, 32'hAB);
    ring(3);
    wait_frames(3);
    repeat (50) @(negedge clk);
    chk(nfr == 3, "R3 three bells three frames", nfr, 3);
    chk(!rd_req_o, "R3 idle without credit", rd_req_o, 0);
    chk(g_addr[0] == 64'hAB_0000_0000, "R2 first read at base", g_addr[0], 64'hAB_0000_0000);
    chk(g_size[0] == 20 && g_type[0] == 16'h50, "R4 header decode", {g_type[0], g_size[0]}, {16'h50, 16'd20});
    chk(g_addr[1] == 64'hAB_0000_0014, "R5 advance by size", g_addr[1], 64'hAB_0000_0014);
    chk(g_addr[2] == 64'hAB_0000_0024, "R5 round up to 4", g_addr[2], 64'hAB_0000_0024);
    ring(1);
    wait_frames(4);
    chk(nfr == 4 && g_addr[3] == 64'hAB_0000_002C, "R5 rounded 6 to 8", g_addr[3], 64'hAB_0000_002C);
    chk(g_type[3] == 16'h53, "R4 type field", g_type[3], 16'h53);
  endtask

  task automatic t_link;
    hdr(32'h800, 8, 16'h60);
    hdr(32'h808, 12, 16'h1001); mem[32'h80C >> 2] = 32'h0; mem[32'h810 >> 2] = 32'h12;
    hdr(32'h000, 4, 16'h61);
    load_base(32'h800, 32'h0);
    ring(2);
    wait_frames(2);
    repeat (20) @(negedge clk);
    chk(nfr == 2, "R6 link uses no credit", nfr, 2);
    chk(g_addr[1] == 64'h12_0000_0000, "R6 jump to linked page", g_addr[1], 64'h12_0000_0000);
    chk(g_type[1] == 16'h61, "R6 frame after link", g_type[1], 16'h61);
    chk(nlink == 1, "R7 one link pulse", nlink, 1);
  endtask

  task automatic t_edge;
    hdr(32'h000, 2036, 16'h70);
    hdr(32'h7F4, 12, 16'h1001); mem[32'h7F8 >> 2] = 32'h800; mem[32'h7FC >> 2] = 32'h0;
    hdr(32'h800, 4, 16'h71);
    load_base(32'h0, 32'h0);
    ring(2);
    wait_frames(2);
    repeat (10) @(negedge clk);
    chk(nfr == 2 && !err_o, "R10 record ends on page end", {err_o, 8'(nfr)}, 2);
    chk(g_addr[1] == 64'h800 && nlink == 1, "R10 link at page tail", g_addr[1], 64'h800);
  endtask

  task automatic t_err;
    hdr(32'h000, 0, 16'h80);
    load_base(32'h0, 32'h0);
    ring(1);
    repeat (30) @(negedge clk);
    chk(err_o && nfr == 0, "R8 zero size halts", {err_o, 8'(nfr)}, {1'b1, 8'd0});
    chk(!rd_req_o, "R8 no reads after error", rd_req_o, 0);
    @(negedge clk) hold_i = 1'b1;
    @(negedge clk);
    chk(!err_o, "R9 hold clears error", err_o, 0);
    hdr(32'h000, 2044, 16'h81); hdr(32'h7FC, 8, 16'h82);
    load_base(32'h0, 32'h0);
    ring(2);
    repeat (40) @(negedge clk);
    chk(err_o && nfr == 1, "R8 page overrun halts", {err_o, 8'(nfr)}, {1'b1, 8'd1});
    hdr(32'h000, 8, 16'h1001);
    load_base(32'h0, 32'h0);
    ring(1);
    repeat (30) @(negedge clk);
    chk(err_o && nlink == 0, "R8 bad link size", {err_o, 8'(nlink)}, {1'b1, 8'd0});
  endtask

  task automatic t_hold;
    logic [63:0] a0;
    hdr(32'h000, 8, 16'h33); hdr(32'h400, 8, 16'h44);
    frm_ready_i = 1'b0;
    load_base(32'h0, 32'h0);
    ring(3);
    repeat (20) @(negedge clk);
    a0 = frm_addr_o;
    chk(frm_valid_o && nfr == 0, "R4 frame waits for ready", frm_valid_o, 1);
    repeat (5) @(negedge clk);
    chk(frm_valid_o && frm_addr_o == a0, "R4 frame stable in stall", frm_addr_o, a0);
    hold_i = 1'b1;
    @(negedge clk);
    chk(!frm_valid_o, "R9 hold aborts frame", frm_valid_o, 0);
    bell_i = 1'b1; @(negedge clk) bell_i = 1'b0;
    frm_ready_i = 1'b1;
    @(negedge clk) hold_i = 1'b0; nfr = 0;
    repeat (40) @(negedge clk);
    chk(nfr == 0, "R9 credit cleared and hold bells ignored", nfr, 0);
    base_lo_wr_i = 1'b1; base_data_i = 32'h400;
    @(negedge clk) base_lo_wr_i = 1'b0;
    hold_i = 1'b1;
    repeat (3) @(negedge clk);
    hold_i = 1'b0; nfr = 0;
    ring(1);
    wait_frames(1);
    chk(nfr == 1 && g_type[0] == 16'h33, "R2 base write outside hold ignored", g_type[0], 16'h33);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_link();
    t_edge();
    t_err();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule